// File: doc/BRIEF.md
# Double-Data-Rate Read Capture with Transfer-Clock Polarity Select

This block takes read data coming back from a double-data-rate memory and lands it in the system clock domain. It receives the data bus and a strobe that has already been shifted by a quarter period, so each data bit is stable around every strobe edge. One register per bit takes the bus on the strobe's rising edge and another takes it on the falling edge. A third register moves the rising-edge word onto the falling edge, so that both halves of one strobe period are held together for a full strobe period.

A preamble-detect input goes high ahead of each read burst. On its rising edge the block samples the level of the system clock. A high level makes the transfer registers run on the inverted system clock, and a low level keeps the true clock. This choice places the transfer edge in the half period after the strobe's falling edge, which is where the aligned pair is stable. The chosen polarity is held for the whole burst. Further preamble edges are ignored until the burst has been delivered.

The output is a valid-only stream: `word_valid` marks each transfer-clock cycle that carries a new pair. There is no ready input, because a memory read cannot be stalled, so no back-pressure is possible. The consumer must take the pair in every cycle where `word_valid` is high, and it sees `BURST_PAIRS` such cycles per burst, one after another.

Top module: `ddr_read_capture`

## Requirements
- R1: While `rst_n` is low, `rise_word` and `fall_word` are all zero and `word_valid` and `clk_inv` are 0.
- R2: `rise_word` carries the value of `dq` at a rising edge of `dqs_dly`. Within each strobe period, the rising-edge word is the first word of the pair.
- R3: `fall_word` carries the value of `dq` at the falling edge of the same strobe period. It is presented in the same cycle as that period's rising-edge word.
- R4: At the accepted rising edge of `preamble`, `clk_inv` takes the level of `sys_clk`: a low level gives 0 (true clock) and a high level gives 1 (inverted clock).
- R5: The outputs change only on rising edges of the transfer clock and hold their values between those edges. The transfer clock is `sys_clk` when `clk_inv` is 0 and the inverse of `sys_clk` when `clk_inv` is 1.
- R6: After an accepted preamble edge, `word_valid` is high for exactly `BURST_PAIRS` consecutive transfer cycles. The first of these cycles starts at the second transfer-clock rising edge after the preamble edge. The pairs come out in the order they were sent. The first strobe rising edge follows the preamble edge by half a strobe period.
- R7: A rising edge of `preamble` is ignored while a burst is in progress. A burst is in progress from its acceptance until the transfer edge that follows its last valid cycle. An ignored edge changes neither `clk_inv` nor the number or content of the valid cycles.
- R8: Once a burst has finished, the next preamble edge is accepted and may select the other polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| sys_clk | input | 1 | System clock |
| dqs_dly | input | 1 | Read strobe after the quarter-period shift |
| preamble | input | 1 | Preamble detect; its rising edge opens a burst |
| dq | input | DQ_W | Read data bus, edge aligned to the raw strobe |
| rise_word | output | DQ_W | Rising-edge data word of the current pair |
| fall_word | output | DQ_W | Falling-edge data word of the current pair |
| word_valid | output | 1 | High in each transfer cycle that carries a new pair |
| clk_inv | output | 1 | 1 when the transfer registers run on the inverted system clock |

## Verification
The assertions assume the following about the inputs:
- `dq` is steady around every `dqs_dly` edge.
- The strobe is quiet while reset is applied.
- The preamble rising edge never coincides with a `sys_clk` edge.
- The strobe and the system clock run at the same frequency, with the first strobe rising edge half a period after the preamble.

Under these conditions, the realigned rising word always equals the value the rising register held one falling edge earlier, and the polarity stays fixed while a burst is in flight. The stimulus meets the assumptions by construction. It places each preamble at a strobe phase off the 4 ns clock-edge grid, changes `dq` a quarter period before each strobe edge, and starts the strobe only after reset is released.

// File: rtl/rdcap_pkg.sv
`timescale 1ns/100ps
package rdcap_pkg;

  // Transfer-side burst sequencing
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,  // waiting for an accepted preamble
    XS_LEAD   = 2'd1,  // first transfer edge, pair not yet aligned
    XS_STREAM = 2'd2   // pairs being delivered
  } xfer_state_e;

  function automatic int count_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rdcap_bitslice.sv
`timescale 1ns/100ps
module rdcap_bitslice (
  input  logic rst_n,
  input  logic strobe,
  input  logic dq_bit,
  output logic rise_bit,
  output logic fall_bit
);

  logic rise_q;   // taken on strobe rise
  logic fall_q;   // taken on strobe fall
  logic align_q;  // rise_q moved onto strobe fall

  always_ff @(posedge strobe or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= dq_bit;
  end

  always_ff @(negedge strobe or negedge rst_n) begin
    if (!rst_n) begin
      fall_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      fall_q  <= dq_bit;
      align_q <= rise_q;
    end
  end

  assign rise_bit = align_q;
  assign fall_bit = fall_q;

  AST_RISE_REALIGN: assert property (@(negedge strobe) disable iff (!rst_n)
    align_q == $past(rise_q)); // R3

endmodule

// File: rtl/rdcap_polarity.sv
`timescale 1ns/100ps
module rdcap_polarity (
  input  logic rst_n,
  input  logic sys_clk,
  input  logic preamble,
  input  logic ack_tgl,
  output logic req_tgl,
  output logic clk_inv,
  output logic xfer_clk
);

  logic pol_q;
  logic req_q;

  // Accept a preamble edge only when the transfer side has retired the
  // previous burst (request and acknowledge toggles equal).
  always_ff @(posedge preamble or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      req_q <= 1'b0;
    end else if (req_q == ack_tgl) begin
      pol_q <= sys_clk;
      req_q <= ~req_q;
    end
  end

  // After an update xfer_clk = sys_clk ^ sys_clk = 0, so a polarity change
  // can only produce a falling edge, never a spurious rising one.
  assign xfer_clk = sys_clk ^ pol_q;
  assign clk_inv  = pol_q;
  assign req_tgl  = req_q;

endmodule

// File: rtl/rdcap_xfer.sv
`timescale 1ns/100ps
module rdcap_xfer #(
  parameter int DQ_W        = 8,
  parameter int BURST_PAIRS = 4
) (
  input  logic            rst_n,
  input  logic            xfer_clk,
  input  logic [DQ_W-1:0] rise_in,
  input  logic [DQ_W-1:0] fall_in,
  input  logic            req_tgl,
  input  logic            clk_inv,
  output logic            ack_tgl,
  output logic [DQ_W-1:0] rise_word,
  output logic [DQ_W-1:0] fall_word,
  output logic            word_valid
);
  import rdcap_pkg::*;

  localparam int CNT_W = count_width(BURST_PAIRS);
  localparam logic [CNT_W-1:0] LAST_LEFT = CNT_W'(BURST_PAIRS - 1);
  localparam logic [CNT_W-1:0] RUN_MAX   = CNT_W'(BURST_PAIRS);

  xfer_state_e      state_q;
  logic [CNT_W-1:0] left_q;
  logic             ack_q;
  logic             valid_q;
  logic [DQ_W-1:0]  rise_q;
  logic [DQ_W-1:0]  fall_q;

  // Transfer registers run every edge; valid marks the ones that matter.
  always_ff @(posedge xfer_clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_in;
      fall_q <= fall_in;
    end
  end

  always_ff @(posedge xfer_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      left_q  <= '0;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          valid_q <= 1'b0;
          if (req_tgl != ack_q) state_q <= XS_LEAD;
        end
        XS_LEAD: begin
          valid_q <= 1'b1;
          left_q  <= LAST_LEFT;
          state_q <= XS_STREAM;
        end
        XS_STREAM: begin
          if (left_q != '0) begin
            valid_q <= 1'b1;
            left_q  <= left_q - 1'b1;
          end else begin
            valid_q <= 1'b0;
            ack_q   <= req_tgl;
            state_q <= XS_IDLE;
          end
        end
        default: begin
          valid_q <= 1'b0;
          state_q <= XS_IDLE;
        end
      endcase
    end
  end

  assign ack_tgl    = ack_q;
  assign rise_word  = rise_q;
  assign fall_word  = fall_q;
  assign word_valid = valid_q;

  // Checker: length of the current run of valid cycles
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge xfer_clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (valid_q) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  AST_RUN_BOUNDED: assert property (@(posedge xfer_clk) disable iff (!rst_n)
    valid_q |-> (run_q < RUN_MAX)); // R6
  AST_VALID_NEEDS_REQ: assert property (@(posedge xfer_clk) disable iff (!rst_n)
    $rose(valid_q) |-> (req_tgl != ack_q)); // R6
  AST_POL_HELD: assert property (@(posedge xfer_clk) disable iff (!rst_n)
    (state_q != XS_IDLE) |-> $stable(clk_inv)); // R7

endmodule

// File: rtl/ddr_read_capture.sv
`timescale 1ns/100ps
module ddr_read_capture #(
  parameter int DQ_W        = 8,
  parameter int BURST_PAIRS = 4
) (
  input  logic            rst_n,
  input  logic            sys_clk,
  input  logic            dqs_dly,
  input  logic            preamble,
  input  logic [DQ_W-1:0] dq,
  output logic [DQ_W-1:0] rise_word,
  output logic [DQ_W-1:0] fall_word,
  output logic            word_valid,
  output logic            clk_inv
);

  logic [DQ_W-1:0] rise_al;
  logic [DQ_W-1:0] fall_al;
  logic            xfer_clk;
  logic            req_tgl;
  logic            ack_tgl;

  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    rdcap_bitslice u_lane (
      .rst_n    (rst_n),
      .strobe   (dqs_dly),
      .dq_bit   (dq[i]),
      .rise_bit (rise_al[i]),
      .fall_bit (fall_al[i])
    );
  end

  rdcap_polarity u_pol (
    .rst_n    (rst_n),
    .sys_clk  (sys_clk),
    .preamble (preamble),
    .ack_tgl  (ack_tgl),
    .req_tgl  (req_tgl),
    .clk_inv  (clk_inv),
    .xfer_clk (xfer_clk)
  );

  rdcap_xfer #(
    .DQ_W        (DQ_W),
    .BURST_PAIRS (BURST_PAIRS)
  ) u_xfer (
    .rst_n      (rst_n),
    .xfer_clk   (xfer_clk),
    .rise_in    (rise_al),
    .fall_in    (fall_al),
    .req_tgl    (req_tgl),
    .clk_inv    (clk_inv),
    .ack_tgl    (ack_tgl),
    .rise_word  (rise_word),
    .fall_word  (fall_word),
    .word_valid (word_valid)
  );

endmodule

// File: tb/tb_ddr_read_capture.sv
`timescale 1ns/100ps
module tb_ddr_read_capture;

  localparam int W  = 8;
  localparam int BP = 4;

  logic         sys_clk  = 1'b0;
  logic         rst_n    = 1'b0;
  logic         dqs      = 1'b0;
  logic         preamble = 1'b0;
  logic [W-1:0] dq       = '0;
  logic [W-1:0] rise_word, fall_word;
  logic         word_valid, clk_inv;

  logic exp_pol = 1'b0;
  logic xclk;
  assign xclk = sys_clk ^ exp_pol;

  int errs   = 0;
  int checks = 0;

  always #4 sys_clk = ~sys_clk;  // 125 MHz

  ddr_read_capture #(.DQ_W(W), .BURST_PAIRS(BP)) dut (
    .rst_n(rst_n), .sys_clk(sys_clk), .dqs_dly(dqs), .preamble(preamble),
    .dq(dq), .rise_word(rise_word), .fall_word(fall_word),
    .word_valid(word_valid), .clk_inv(clk_inv)
  );

  // Burst table: strobe phase after a sys_clk rise (0.1 ns units),
  // data seed, expected polarity (high clock level when phase < 4 ns).
  localparam int NV = 6;
  localparam int   PHASE [NV] = '{13, 57, 25, 63, 37, 71};
  localparam int   SEED  [NV] = '{8'h11, 8'hA5, 8'h3C, 8'hF0, 8'h69, 8'h07};
  localparam bit   POL   [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  function automatic logic [W-1:0] pword(input int seed, input int k);
    return W'(seed + 74 * k);
  endfunction
  function automatic logic [W-1:0] nword(input int seed, input int k);
    return W'(seed + 74 * k + 37) ^ W'(8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_burst(input int phase, input int seed, input bit epol,
                             input bit glitch);
    @(posedge sys_clk);
    #(phase * 0.1);
    exp_pol  = epol;
    preamble = 1'b1;
    for (int k = 0; k < BP; k++) begin
      #2 dq = pword(seed, k);
      #2 dqs = 1'b1;
      if (glitch && k == 2) begin
        #0.5 preamble = 1'b0;
        #0.5 preamble = 1'b1;   // lands in the opposite clock phase
        #1;
      end else begin
        #2;
      end
      dq = nword(seed, k);
      #2 dqs = 1'b0;
    end
    #1 dq = '0;
    #2 preamble = 1'b0;
  endtask

  task automatic collect(input int seed, input bit epol, input string pol_req,
                         input string cnt_req);
    int nv = 0;
    for (int e = 0; e < BP + 5; e++) begin
      logic v1;
      logic [W-1:0] r1, f1;
      @(posedge xclk); #1;
      v1 = word_valid; r1 = rise_word; f1 = fall_word;
      if (v1) begin
        chk(r1 == pword(seed, nv), "R2", "rise word", 64'(r1), 64'(pword(seed, nv)));
        chk(f1 == nword(seed, nv), "R3", "fall word", 64'(f1), 64'(nword(seed, nv)));
        nv++;
      end
      @(negedge xclk); #1;
      chk(word_valid == v1 && rise_word == r1 && fall_word == f1, "R5",
          "outputs moved between transfer edges",
          {31'd0, word_valid, rise_word, fall_word}, {31'd0, v1, r1, f1});
    end
    chk(nv == BP, cnt_req, "valid cycle count", 64'(nv), 64'(BP));
    chk(clk_inv == epol, pol_req, "polarity flag", 64'(clk_inv), 64'(epol));
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog R6 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    #15;
    chk(rise_word == '0, "R1", "rise word in reset", 64'(rise_word), 64'd0);
    chk(fall_word == '0, "R1", "fall word in reset", 64'(fall_word), 64'd0);
    chk(word_valid == 1'b0, "R1", "valid in reset", 64'(word_valid), 64'd0);
    chk(clk_inv == 1'b0, "R1", "polarity in reset", 64'(clk_inv), 64'd0);
    #10 rst_n = 1'b1;
    #20;

    // Table walk: alternating polarity, back-to-back bursts (R4, R8)
    for (int i = 0; i < NV; i++) begin
      fork
        drive_burst(PHASE[i], SEED[i], POL[i], 1'b0);
        collect(SEED[i], POL[i], (i == 0) ? "R4" : "R8", "R6");
      join
      #10;
    end

    // R7: preamble re-rises mid-burst in the opposite clock phase
    fork
      drive_burst(13, 8'hC3, 1'b1, 1'b1);
      collect(8'hC3, 1'b1, "R7", "R7");
    join
    #10;
    fork
      drive_burst(57, 8'h2E, 1'b0, 1'b1);
      collect(8'h2E, 1'b0, "R7", "R7");
    join
    #10;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule